// File: doc/BRIEF.md
# Streaming Sector Fail-Bit Grader

This block grades read data while a memory device is still streaming it. Each accepted beat carries an error vector, the bitwise difference between the read data and the expected data, plus tags naming the device and the block it came from. The block adds up failing bits for the current correction sector and compares the total against four correction-limit profiles in parallel. When the sector's last beat arrives, it produces the sector's count, a per-profile pass vector and a grade bin. Because of this, no fail bitmap has to be kept for later analysis.

Sector length is a count of beats and is set on a configuration input. Each profile has its own limit. A table of bad blocks, one bit for each device and block pair, marks the blocks to skip. Beats from a masked block are still accepted, but they add nothing to the count. A sector that ends on a masked beat produces no result. Results leave on a valid/ready handshake. While a result waits to be taken, the input side holds its ready low.

Top module: `fg_sector_grader`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the sector count and beat position are zero.
- R2: A beat is accepted when `in_valid` and `in_ready` are both 1. An unmasked accepted beat adds the number of 1 bits in `in_err` to the sector count, where bit i set means data bit i failed.
- R3: The sector count saturates at 255 and never wraps.
- R4: An accepted beat ends the sector when the number of beats accepted in the sector, including that beat, reaches `sect_len`. A `sect_len` of 0 acts as 1. The next sector starts with a count of 0.
- R5: `out_pass[p]` is 1 exactly when the reported count is less than or equal to the limit of profile p, which sits in `prof_limit[8p+7:8p]`.
- R6: `out_bin` is the lowest profile index p with `out_pass[p]` = 1. It is 4 when no profile passes.
- R7: The mask bit for a beat is `bad_mask[dev*16 + block]`. A masked beat is accepted but adds 0 to the count. A sector whose ending beat is masked produces no result.
- R8: While `out_valid` is 1, `in_ready` is 0. `out_valid` and all result fields hold unchanged until `out_ready` is 1.
- R9: A result appears on the cycle after its ending beat is accepted. `out_dev` and `out_block` carry that beat's tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be accepted |
| in_err | input | 8 | Error vector of the beat (1 = failing bit) |
| in_dev | input | 2 | Device index of the beat |
| in_block | input | 4 | Block address of the beat |
| sect_len | input | 6 | Beats per sector (0 acts as 1) |
| prof_limit | input | 32 | Four 8-bit correction limits, profile p in bits 8p+7:8p |
| bad_mask | input | 64 | Bad-block table, bit dev*16+block |
| out_valid | output | 1 | Sector result present |
| out_ready | input | 1 | Result taken |
| out_count | output | 8 | Saturated fail-bit count of the sector |
| out_pass | output | 4 | Per-profile pass flags |
| out_bin | output | 3 | Grade bin, 4 = reject |
| out_dev | output | 2 | Device tag of the ending beat |
| out_block | output | 4 | Block tag of the ending beat |

## Verification
On every cycle, the assertions check the following: the count never drops in the middle of a sector, a masked beat leaves the count unchanged, the sector restarts at zero, the input stalls while a result is pending, a result held under back-pressure stays stable, and the grade bin agrees with the pass vector. Some behaviours can only be shown by the bench's scenarios, which check against a behavioural model: the exact popcount sums, saturation over long all-failing sectors, one-beat sectors when `sect_len` is 0, dropped results for masked blocks, and reject bins when the limits are tight.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int unsigned FG_ERR_W  = 8;
  localparam int unsigned FG_CNT_W  = 8;
  localparam int unsigned FG_NPROF  = 4;
  localparam int unsigned FG_SECT_W = 6;
  localparam int unsigned FG_DEV_W  = 2;
  localparam int unsigned FG_BLK_W  = 4;

  // number of set bits in a vector of up to 32 bits
  function automatic int unsigned fg_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // addition clipped at a ceiling
  function automatic int unsigned fg_sat_add(input int unsigned a, input int unsigned b,
                                             input int unsigned ceil);
    int unsigned s;
    s = a + b;
    return (s > ceil) ? ceil : s;
  endfunction
endpackage

// File: rtl/fg_accum.sv
module fg_accum
  import fg_pkg::*;
#(
  parameter int unsigned ERR_W  = FG_ERR_W,
  parameter int unsigned CNT_W  = FG_CNT_W,
  parameter int unsigned SECT_W = FG_SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              beat_masked,
  input  logic [ERR_W-1:0]  beat_err,
  input  logic [SECT_W-1:0] sect_len,
  output logic              sect_end,
  output logic [CNT_W-1:0]  sect_total
);
  localparam int unsigned CEIL = (1 << CNT_W) - 1;

  logic [CNT_W-1:0]  acc;
  logic [SECT_W-1:0] beat_pos;
  logic [SECT_W:0]   next_pos;
  logic [SECT_W:0]   eff_len;
  int unsigned       beat_add;
  int unsigned       sum_i;

  always_comb begin
    beat_add   = beat_masked ? 0 : fg_ones(32'(beat_err));
    sum_i      = fg_sat_add(32'(acc), beat_add, CEIL);
    sect_total = CNT_W'(sum_i);
    next_pos   = {1'b0, beat_pos} + (SECT_W+1)'(1);
    eff_len    = (sect_len == '0) ? (SECT_W+1)'(1) : {1'b0, sect_len};
    sect_end   = beat_fire && (next_pos >= eff_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      beat_pos <= '0;
    end else if (beat_fire) begin
      if (sect_end) begin
        acc      <= '0;
        beat_pos <= '0;
      end else begin
        acc      <= sect_total;
        beat_pos <= next_pos[SECT_W-1:0];
      end
    end
  end

  // R3: inside a sector the count only grows (saturation, no wrap)
  p_count_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !sect_end |=> acc >= $past(acc));
  // R7: a masked beat leaves the count untouched
  p_masked_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && beat_masked && !sect_end |=> acc == $past(acc));
  // R4: the sector after an ending beat starts from zero
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sect_end |=> acc == '0 && beat_pos == '0);
endmodule

// File: rtl/fg_grade.sv
module fg_grade
  import fg_pkg::*;
#(
  parameter int unsigned CNT_W = FG_CNT_W,
  parameter int unsigned NPROF = FG_NPROF,
  localparam int unsigned BIN_W = $clog2(NPROF + 1)
) (
  input  logic [CNT_W-1:0]       total,
  input  logic [NPROF*CNT_W-1:0] limits,
  output logic [NPROF-1:0]       pass,
  output logic [BIN_W-1:0]       bin
);
  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    assign pass[p] = (total <= limits[p*CNT_W +: CNT_W]);
  end

  always_comb begin
    bin = BIN_W'(NPROF);
    for (int p = NPROF - 1; p >= 0; p--) begin
      if (pass[p]) bin = BIN_W'(p);
    end
  end
endmodule

// File: rtl/fg_result.sv
module fg_result
  import fg_pkg::*;
#(
  parameter int unsigned CNT_W = FG_CNT_W,
  parameter int unsigned NPROF = FG_NPROF,
  parameter int unsigned TAG_W = FG_DEV_W + FG_BLK_W,
  localparam int unsigned BIN_W = $clog2(NPROF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_count,
  input  logic [NPROF-1:0] ld_pass,
  input  logic [BIN_W-1:0] ld_bin,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_count,
  output logic [NPROF-1:0] out_pass,
  output logic [BIN_W-1:0] out_bin,
  output logic [TAG_W-1:0] out_tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
      out_pass  <= '0;
      out_bin   <= '0;
      out_tag   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_count <= ld_count;
      out_pass  <= ld_pass;
      out_bin   <= ld_bin;
      out_tag   <= ld_tag;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a pending result is stable until taken
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_count) && $stable(out_pass)
                                && $stable(out_bin) && $stable(out_tag));
  // R8: no new result is loaded over a pending one
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/fg_sector_grader.sv
module fg_sector_grader
  import fg_pkg::*;
#(
  parameter int unsigned ERR_W  = FG_ERR_W,
  parameter int unsigned CNT_W  = FG_CNT_W,
  parameter int unsigned NPROF  = FG_NPROF,
  parameter int unsigned SECT_W = FG_SECT_W,
  parameter int unsigned DEV_W  = FG_DEV_W,
  parameter int unsigned BLK_W  = FG_BLK_W,
  localparam int unsigned BIN_W  = $clog2(NPROF + 1),
  localparam int unsigned PIDX_W = (NPROF > 1) ? $clog2(NPROF) : 1,
  localparam int unsigned TAG_W  = DEV_W + BLK_W,
  localparam int unsigned MASK_N = 1 << TAG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ERR_W-1:0]       in_err,
  input  logic [DEV_W-1:0]       in_dev,
  input  logic [BLK_W-1:0]       in_block,
  input  logic [SECT_W-1:0]      sect_len,
  input  logic [NPROF*CNT_W-1:0] prof_limit,
  input  logic [MASK_N-1:0]      bad_mask,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CNT_W-1:0]       out_count,
  output logic [NPROF-1:0]       out_pass,
  output logic [BIN_W-1:0]       out_bin,
  output logic [DEV_W-1:0]       out_dev,
  output logic [BLK_W-1:0]       out_block
);
  // named internal events
  logic             beat_fire;
  logic             beat_masked;
  logic [TAG_W-1:0] beat_tag;
  logic             sect_end;
  logic             emit;
  logic [CNT_W-1:0] sect_total;
  logic [NPROF-1:0] grade_pass;
  logic [BIN_W-1:0] grade_bin;
  logic [TAG_W-1:0] res_tag;

  assign in_ready    = !out_valid;
  assign beat_fire   = in_valid && in_ready;
  assign beat_tag    = {in_dev, in_block};
  assign beat_masked = bad_mask[beat_tag];
  assign emit        = sect_end && !beat_masked;

  fg_accum #(.ERR_W(ERR_W), .CNT_W(CNT_W), .SECT_W(SECT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .beat_masked(beat_masked),
    .beat_err(in_err), .sect_len(sect_len), .sect_end(sect_end), .sect_total(sect_total));

  fg_grade #(.CNT_W(CNT_W), .NPROF(NPROF)) u_grade (
    .total(sect_total), .limits(prof_limit), .pass(grade_pass), .bin(grade_bin));

  fg_result #(.CNT_W(CNT_W), .NPROF(NPROF), .TAG_W(TAG_W)) u_result (
    .clk(clk), .rst_n(rst_n), .load(emit), .ld_count(sect_total), .ld_pass(grade_pass),
    .ld_bin(grade_bin), .ld_tag(beat_tag), .out_ready(out_ready), .out_valid(out_valid),
    .out_count(out_count), .out_pass(out_pass), .out_bin(out_bin), .out_tag(res_tag));

  assign out_dev   = res_tag[TAG_W-1:BLK_W];
  assign out_block = res_tag[BLK_W-1:0];

  // R8: input stalled while a result waits
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R6: a non-reject bin names a passing profile
  p_bin_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bin != BIN_W'(NPROF) |-> out_pass[out_bin[PIDX_W-1:0]]);
  // R6: reject bin only when every profile fails
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bin == BIN_W'(NPROF) |-> out_pass == '0);
  // R7: a sector ending on a masked beat emits nothing
  p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sect_end && beat_masked |=> !out_valid);
  // R9: an unmasked sector end produces a result next cycle
  p_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> out_valid);
endmodule

// File: tb/fg_sector_grader_test.sv
module fg_sector_grader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_err = '0;
  logic [1:0]  in_dev = '0;
  logic [3:0]  in_block = '0;
  logic [5:0]  sect_len = 6'd4;
  logic [31:0] prof_limit = '0;
  logic [63:0] bad_mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_count;
  logic [3:0]  out_pass;
  logic [2:0]  out_bin;
  logic [1:0]  out_dev;
  logic [3:0]  out_block;

  fg_sector_grader uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_err(in_err),
    .in_dev(in_dev), .in_block(in_block), .sect_len(sect_len), .prof_limit(prof_limit),
    .bad_mask(bad_mask), .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
    .out_pass(out_pass), .out_bin(out_bin), .out_dev(out_dev), .out_block(out_block));

  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit sat_phase = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int m_acc = 0, m_beats = 0, m_count = 0, m_bin = 0, m_dev = 0, m_blk = 0;
  bit m_ov = 1'b0;
  bit [3:0] m_pass = '0;

  task automatic report(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_beats = 0; m_ov = 1'b0;
    end else begin
      bit fire;
      fire = in_valid && !m_ov;
      if (m_ov && out_ready) m_ov = 1'b0;
      if (fire) begin
        bit masked;
        int ones, lim;
        masked = bad_mask[int'(in_dev) * 16 + int'(in_block)];
        ones = 0;
        if (!masked) for (int i = 0; i < 8; i++) if (in_err[i]) ones++;
        m_acc = m_acc + ones;
        if (m_acc > 255) m_acc = 255;
        m_beats++;
        lim = (sect_len == 0) ? 1 : int'(sect_len);
        if (m_beats >= lim) begin
          if (!masked) begin
            m_ov = 1'b1;
            m_count = m_acc;
            m_dev = int'(in_dev);
            m_blk = int'(in_block);
            m_bin = 4;
            for (int p = 0; p < 4; p++) m_pass[p] = (m_acc <= int'(prof_limit[p*8 +: 8]));
            for (int p = 3; p >= 0; p--) if (m_pass[p]) m_bin = p;
          end
          m_acc = 0;
          m_beats = 0;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      report("R8", "in_ready", int'(in_ready), int'(!m_ov));
      report("R7/R9", "out_valid", int'(out_valid), int'(m_ov));
      if (m_ov && out_valid) begin
        report("R2/R3/R4", "out_count", int'(out_count), m_count);
        report("R5", "out_pass", int'(out_pass), int'(m_pass));
        report("R6", "out_bin", int'(out_bin), m_bin);
        report("R9", "out_dev", int'(out_dev), m_dev);
        report("R9", "out_block", int'(out_block), m_blk);
        if (sat_phase) report("R3", "saturated count", int'(out_count), 255);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic run(input int n, input int vpct, input int rpct, input bit dense, input bit allones);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid  = ($urandom % 100) < vpct;
      out_ready = ($urandom % 100) < rpct;
      in_err    = allones ? 8'hFF : (dense ? 8'($urandom) : 8'($urandom) & 8'($urandom) & 8'($urandom));
      in_dev    = 2'($urandom);
      in_block  = 4'($urandom);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state visible at the ports
    report("R1", "out_valid at reset", int'(out_valid), 0);
    report("R1", "in_ready at reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1", "out_valid after reset", int'(out_valid), 0);

    // R2 R4 R5 R6: four-beat sectors, ascending limits, back-pressure
    sect_len = 6'd4;
    prof_limit = {8'd10, 8'd5, 8'd2, 8'd0};
    run(600, 75, 60, 1'b0, 1'b0);
    drain();

    // R4: length 0 behaves as one-beat sectors
    sect_len = 6'd0;
    prof_limit = {8'd6, 8'd3, 8'd1, 8'd0};
    run(300, 80, 100, 1'b1, 1'b0);
    drain();

    // R3: long all-failing sectors saturate at 255
    sect_len = 6'd63;
    prof_limit = {8'd254, 8'd200, 8'd100, 8'd50};
    sat_phase = 1'b1;
    run(400, 100, 100, 1'b0, 1'b1);
    drain();
    sat_phase = 1'b0;
    drain();

    // R7: bad-block table masks beats and suppresses results
    sect_len = 6'd3;
    bad_mask = {32'($urandom), 32'($urandom)};
    prof_limit = {8'd9, 8'd4, 8'd2, 8'd1};
    run(800, 70, 70, 1'b1, 1'b0);
    drain();
    bad_mask = '1;
    run(100, 90, 90, 1'b1, 1'b0);
    drain();
    bad_mask = '0;

    // R6: tight limits push sectors into the reject bin
    sect_len = 6'd5;
    prof_limit = {8'd1, 8'd1, 8'd0, 8'd0};
    run(400, 85, 50, 1'b1, 1'b0);
    drain();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule